// File: doc/BRIEF.md
# Serial Ratio Loader for a Frequency Synthesizer

This block takes ratio settings for a frequency synthesizer over a three-wire serial link: a data line, a data clock and a latch strobe. Every rising edge of the data clock moves one bit into a 19-bit shift register. The word arrives high bit first and ends with a steering bit. When the latch strobe rises, the steering bit picks the destination for the rest of the word. A low steering bit sends it to the main divider register, which holds a 7-bit swallow ratio and an 11-bit counter ratio. A high steering bit sends it to a reference ratio register.

The main register refuses any counter ratio below a set minimum, because such a ratio cannot be used. Each accepted load sends a pulse to the divider clock domain. The pulse crosses through a toggle and a flop synchroniser and comes out as a strobe one divider clock wide. A sticky flag shows that the main register has received at least one usable setting since reset.

Top module: `synth_ratio_loader`

## Requirements
- R1: The shift register advances one bit on each rising edge of `sclk_i`. A new bit enters at position 0 and older bits move up. Only the last 19 bits shifted before a latch edge count, and any earlier bits fall off the top.
- R2: Within the latched word, bit 0 is the steering bit. Bits 7..1 are the swallow ratio, with bit 1 as its LSB. Bits 18..8 are the counter ratio, with bit 8 as its LSB.
- R3: On a rising `le_i` with steering bit 0 and a counter ratio of at least 16, `main_swal_o` and `main_cnt_o` take the word's fields, and `ref_ratio_o` is left unchanged.
- R4: On a rising `le_i` with steering bit 1, `ref_ratio_o` takes word bits REF_W..1 (14..1 by default), and the main outputs are left unchanged.
- R5: A word with steering bit 0 and a counter ratio below 16 is ignored. The main outputs keep their values and no strobe is produced.
- R6: The registers load only on a rising edge of `le_i`. While `le_i` is held high the shift register keeps shifting, and nothing loads until the next rising edge.
- R7: Each accepted main load raises `main_load_o` for exactly one `dclk_i` cycle, and each reference load does the same on `ref_load_o`. A load never raises the other strobe.
- R8: Reset sets all ratio outputs to zero and `main_ok_o` low. `main_ok_o` rises with the first accepted main load and stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, all domains |
| sclk_i | input | 1 | Serial data clock; shifts on rising edge |
| sdata_i | input | 1 | Serial data, high bit first, steering bit last |
| le_i | input | 1 | Latch strobe; loads on rising edge |
| dclk_i | input | 1 | Divider-domain clock for the load strobes |
| main_swal_o | output | 7 | Latched swallow ratio |
| main_cnt_o | output | 11 | Latched counter ratio |
| ref_ratio_o | output | 14 | Latched reference ratio |
| main_load_o | output | 1 | One-cycle strobe in `dclk_i` domain after a main load |
| ref_load_o | output | 1 | One-cycle strobe in `dclk_i` domain after a reference load |
| main_ok_o | output | 1 | High once a usable main setting has been loaded |

## Verification
The properties assume that `le_i` never rises on the same instant as an `sclk_i` edge, so the shift word is settled when it is latched. They also assume that successive latch pulses are further apart than the synchroniser delay, so no two toggles merge into one strobe. The stimulus changes `le_i` only while `sclk_i` is low, and always two time units after a falling divider-clock edge. It also waits eight divider cycles after each pulse before doing anything else.

// File: rtl/slr_pkg.sv
package slr_pkg;
   // Destination chosen by the trailing steering bit of a serial word
   typedef enum logic {
      DEST_MAIN = 1'b0,
      DEST_REF  = 1'b1
   } slr_dest_e;

   localparam int unsigned DEF_SWAL_W  = 7;
   localparam int unsigned DEF_CNT_W   = 11;
   localparam int unsigned DEF_REF_W   = 14;
   localparam int unsigned DEF_MIN_CNT = 16;
   localparam int unsigned DEF_SYNC_N  = 2;
endpackage

// File: rtl/slr_shifter.sv
module slr_shifter #(
   parameter int unsigned WORD_W = 19
) (
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              sdata_i,
   output logic [WORD_W-1:0] word_o
);
   initial begin
      if (WORD_W < 2) $error("slr_shifter: WORD_W must be at least 2");
   end

   logic [WORD_W-1:0] sreg_q;

   always_ff @(posedge sclk_i or negedge rst_n) begin
      if (!rst_n) sreg_q <= '0;
      else        sreg_q <= {sreg_q[WORD_W-2:0], sdata_i};
   end

   assign word_o = sreg_q;
endmodule

// File: rtl/slr_latch_decode.sv
module slr_latch_decode
   import slr_pkg::*;
#(
   parameter int unsigned SWAL_W  = DEF_SWAL_W,
   parameter int unsigned CNT_W   = DEF_CNT_W,
   parameter int unsigned REF_W   = DEF_REF_W,
   parameter int unsigned MIN_CNT = DEF_MIN_CNT,
   localparam int unsigned WORD_W = 1 + SWAL_W + CNT_W
) (
   input  logic              rst_n,
   input  logic              le_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [SWAL_W-1:0] swal_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [REF_W-1:0]  ref_o,
   output logic              main_tgl_o,
   output logic              ref_tgl_o,
   output logic              ok_o
);
   localparam int unsigned SWAL_LO = 1;
   localparam int unsigned CNT_LO  = SWAL_LO + SWAL_W;

   slr_dest_e         dest;
   logic [SWAL_W-1:0] swal_fld;
   logic [CNT_W-1:0]  cnt_fld;
   logic [REF_W-1:0]  ref_fld;
   logic              cnt_usable;

   always_comb begin
      dest       = slr_dest_e'(word_i[0]);
      swal_fld   = word_i[CNT_LO-1:SWAL_LO];
      cnt_fld    = word_i[WORD_W-1:CNT_LO];
      ref_fld    = word_i[REF_W:1];
      cnt_usable = (32'(cnt_fld) >= MIN_CNT);
   end

   always_ff @(posedge le_i or negedge rst_n) begin
      if (!rst_n) begin
         swal_o     <= '0;
         cnt_o      <= '0;
         ref_o      <= '0;
         main_tgl_o <= 1'b0;
         ref_tgl_o  <= 1'b0;
         ok_o       <= 1'b0;
      end else if (dest == DEST_REF) begin
         ref_o     <= ref_fld;
         ref_tgl_o <= ~ref_tgl_o;
      end else if (cnt_usable) begin
         swal_o     <= swal_fld;
         cnt_o      <= cnt_fld;
         main_tgl_o <= ~main_tgl_o;
         ok_o       <= 1'b1;
      end
   end
endmodule

// File: rtl/slr_pulse_sync.sv
module slr_pulse_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic rst_n,
   input  logic dclk_i,
   input  logic tgl_i,
   output logic pulse_o
);
   initial begin
      if (STAGES < 2) $error("slr_pulse_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge dclk_i or negedge rst_n) begin
            if (!rst_n) sync_q[0] <= 1'b0;
            else        sync_q[0] <= tgl_i;
         end
      end else begin : g_next
         always_ff @(posedge dclk_i or negedge rst_n) begin
            if (!rst_n) sync_q[g] <= 1'b0;
            else        sync_q[g] <= sync_q[g-1];
         end
      end
   end

   always_ff @(posedge dclk_i or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sync_q[STAGES-1];
   end

   assign pulse_o = sync_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/synth_ratio_loader.sv
module synth_ratio_loader
   import slr_pkg::*;
#(
   parameter int unsigned SWAL_W  = DEF_SWAL_W,
   parameter int unsigned CNT_W   = DEF_CNT_W,
   parameter int unsigned REF_W   = DEF_REF_W,
   parameter int unsigned MIN_CNT = DEF_MIN_CNT,
   parameter int unsigned SYNC_N  = DEF_SYNC_N
) (
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              sdata_i,
   input  logic              le_i,
   input  logic              dclk_i,
   output logic [SWAL_W-1:0] main_swal_o,
   output logic [CNT_W-1:0]  main_cnt_o,
   output logic [REF_W-1:0]  ref_ratio_o,
   output logic              main_load_o,
   output logic              ref_load_o,
   output logic              main_ok_o
);
   localparam int unsigned WORD_W = 1 + SWAL_W + CNT_W;

   initial begin
      if (REF_W < 1 || REF_W > WORD_W - 1)
         $error("synth_ratio_loader: REF_W must fit below the steering bit");
      if (MIN_CNT >= (1 << CNT_W))
         $error("synth_ratio_loader: MIN_CNT leaves no usable counter ratio");
   end

   logic [WORD_W-1:0] shift_word;
   logic              main_tgl;
   logic              ref_tgl;

   slr_shifter #(.WORD_W(WORD_W)) u_shift (
      .rst_n   (rst_n),
      .sclk_i  (sclk_i),
      .sdata_i (sdata_i),
      .word_o  (shift_word)
   );

   slr_latch_decode #(
      .SWAL_W  (SWAL_W),
      .CNT_W   (CNT_W),
      .REF_W   (REF_W),
      .MIN_CNT (MIN_CNT)
   ) u_latch (
      .rst_n      (rst_n),
      .le_i       (le_i),
      .word_i     (shift_word),
      .swal_o     (main_swal_o),
      .cnt_o      (main_cnt_o),
      .ref_o      (ref_ratio_o),
      .main_tgl_o (main_tgl),
      .ref_tgl_o  (ref_tgl),
      .ok_o       (main_ok_o)
   );

   slr_pulse_sync #(.STAGES(SYNC_N)) u_main_sync (
      .rst_n   (rst_n),
      .dclk_i  (dclk_i),
      .tgl_i   (main_tgl),
      .pulse_o (main_load_o)
   );

   slr_pulse_sync #(.STAGES(SYNC_N)) u_ref_sync (
      .rst_n   (rst_n),
      .dclk_i  (dclk_i),
      .tgl_i   (ref_tgl),
      .pulse_o (ref_load_o)
   );
endmodule

// File: rtl/slr_checker.sv
module slr_checker #(
   parameter int unsigned SWAL_W  = 7,
   parameter int unsigned CNT_W   = 11,
   parameter int unsigned MIN_CNT = 16,
   parameter int unsigned WORD_W  = 19
) (
   input logic              rst_n,
   input logic              sclk_i,
   input logic              sdata_i,
   input logic              dclk_i,
   input logic [WORD_W-1:0] shift_word,
   input logic [SWAL_W-1:0] main_swal_o,
   input logic [CNT_W-1:0]  main_cnt_o,
   input logic              main_load_o,
   input logic              ref_load_o,
   input logic              main_ok_o
);
   AST_SHIFT_ENTRY: assert property (@(posedge sclk_i) disable iff (!rst_n)
      1'b1 |=> shift_word[0] == $past(sdata_i)); // R1

   AST_SHIFT_MOVE: assert property (@(posedge sclk_i) disable iff (!rst_n)
      1'b1 |=> shift_word[WORD_W-1:1] == $past(shift_word[WORD_W-2:0])); // R1

   AST_MAIN_USABLE: assert property (@(posedge dclk_i) disable iff (!rst_n)
      main_ok_o |-> 32'(main_cnt_o) >= MIN_CNT); // R5

   AST_ZERO_BEFORE_OK: assert property (@(posedge dclk_i) disable iff (!rst_n)
      !main_ok_o |-> (main_cnt_o == '0 && main_swal_o == '0)); // R8

   AST_OK_STICKY: assert property (@(posedge dclk_i) disable iff (!rst_n)
      main_ok_o |=> main_ok_o); // R8

   AST_MLOAD_ONE_CYCLE: assert property (@(posedge dclk_i) disable iff (!rst_n)
      main_load_o |=> !main_load_o); // R7

   AST_RLOAD_ONE_CYCLE: assert property (@(posedge dclk_i) disable iff (!rst_n)
      ref_load_o |=> !ref_load_o); // R7
endmodule

bind synth_ratio_loader slr_checker #(
   .SWAL_W  (SWAL_W),
   .CNT_W   (CNT_W),
   .MIN_CNT (MIN_CNT),
   .WORD_W  (1 + SWAL_W + CNT_W)
) u_chk (
   .rst_n       (rst_n),
   .sclk_i      (sclk_i),
   .sdata_i     (sdata_i),
   .dclk_i      (dclk_i),
   .shift_word  (shift_word),
   .main_swal_o (main_swal_o),
   .main_cnt_o  (main_cnt_o),
   .main_load_o (main_load_o),
   .ref_load_o  (ref_load_o),
   .main_ok_o   (main_ok_o)
);

// File: tb/synth_ratio_loader_tb.sv
module synth_ratio_loader_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 7;

   typedef struct packed {
      logic [18:0] word;
      logic [6:0]  swal;
      logic [10:0] cnt;
      logic [13:0] refr;
      logic        mld;
      logic        rld;
   } vec_t;

   // word = {cnt, swal, 0} for main, {pad, ref, 1} for reference
   localparam vec_t VECS [NVEC] = '{
      '{ {11'd16,   7'd0,   1'b0}, 7'd0,   11'd16,   14'h0000, 1'b1, 1'b0 },
      '{ {11'd2047, 7'd127, 1'b0}, 7'd127, 11'd2047, 14'h0000, 1'b1, 1'b0 },
      '{ {11'd15,   7'd5,   1'b0}, 7'd127, 11'd2047, 14'h0000, 1'b0, 1'b0 },
      '{ {4'hF, 14'h2A5C, 1'b1},   7'd127, 11'd2047, 14'h2A5C, 1'b0, 1'b1 },
      '{ {11'd1000, 7'd77,  1'b0}, 7'd77,  11'd1000, 14'h2A5C, 1'b1, 1'b0 },
      '{ {4'h0, 14'h3FFF, 1'b1},   7'd77,  11'd1000, 14'h3FFF, 1'b0, 1'b1 },
      '{ {11'd0,    7'd127, 1'b0}, 7'd77,  11'd1000, 14'h3FFF, 1'b0, 1'b0 }
   };

   logic        rst_n, sclk, sdata, le, dclk;
   logic [6:0]  swal;
   logic [10:0] cnt;
   logic [13:0] refr;
   logic        mload, rload, ok;
   int          total = 0, bad = 0;
   int          mcount = 0, rcount = 0;

   synth_ratio_loader u_dut (
      .rst_n       (rst_n),
      .sclk_i      (sclk),
      .sdata_i     (sdata),
      .le_i        (le),
      .dclk_i      (dclk),
      .main_swal_o (swal),
      .main_cnt_o  (cnt),
      .ref_ratio_o (refr),
      .main_load_o (mload),
      .ref_load_o  (rload),
      .main_ok_o   (ok)
   );

   initial dclk = 1'b0;
   always #(CLK_PERIOD/2) dclk = ~dclk;

   always @(negedge dclk) begin
      if (mload) mcount++;
      if (rload) rcount++;
   end

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_bits(input logic [31:0] bits, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         sdata = bits[i];
         #7 sclk = 1'b1;
         #7 sclk = 1'b0;
      end
   endtask

   task automatic pulse_le();
      @(negedge dclk); #2 le = 1'b1;
      @(negedge dclk); #2 le = 1'b0;
      repeat (8) @(negedge dclk);
   endtask

   task automatic settle();
      repeat (8) @(negedge dclk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      bad++; total++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int m0, r0;
      rst_n = 1'b0; sclk = 1'b0; sdata = 1'b0; le = 1'b0;
      repeat (3) @(negedge dclk);
      rst_n = 1'b1;
      settle();
      // R8: reset state
      chk("R8 swal reset", swal, 0);
      chk("R8 cnt reset", cnt, 0);
      chk("R8 ref reset", refr, 0);
      chk("R8 ok reset", ok, 0);
      chk("R7 no strobe after reset", mcount + rcount, 0);

      // R5 / R8: a rejected word leaves ok low
      send_bits({13'd0, 11'd10, 7'd3, 1'b0}, 19);
      pulse_le();
      chk("R5 rejected cnt", cnt, 0);
      chk("R5 rejected swal", swal, 0);
      chk("R5 rejected strobe", mcount, 0);
      chk("R8 ok still low", ok, 0);

      // table of vectors: R2 R3 R4 R5 R7
      for (int v = 0; v < NVEC; v++) begin
         m0 = mcount; r0 = rcount;
         send_bits({13'd0, VECS[v].word}, 19);
         pulse_le();
         chk($sformatf("R2 swal vec%0d", v), swal, VECS[v].swal);
         chk($sformatf("R3 cnt vec%0d", v), cnt, VECS[v].cnt);
         chk($sformatf("R4 ref vec%0d", v), refr, VECS[v].refr);
         chk($sformatf("R7 main strobe vec%0d", v), mcount - m0, VECS[v].mld);
         chk($sformatf("R7 ref strobe vec%0d", v), rcount - r0, VECS[v].rld);
         chk($sformatf("R8 ok vec%0d", v), ok, 1);
      end

      // R6: le held high while shifting loads nothing new
      m0 = mcount;
      send_bits({13'd0, 11'd3, 7'd1, 1'b0}, 19);
      @(negedge dclk); #2 le = 1'b1;
      settle();
      send_bits({13'd0, 11'd500, 7'd9, 1'b0}, 19);
      settle();
      chk("R6 held le cnt", cnt, 1000);
      chk("R6 held le swal", swal, 77);
      chk("R6 held le strobe", mcount - m0, 0);
      @(negedge dclk); #2 le = 1'b0;
      settle();
      pulse_le();
      chk("R6 next edge cnt", cnt, 500);
      chk("R6 next edge swal", swal, 9);
      chk("R6 next edge strobe", mcount - m0, 1);

      // R1: extra leading bits fall off the top
      send_bits(32'hF, 4);
      send_bits({13'd0, 11'd33, 7'd3, 1'b0}, 19);
      pulse_le();
      chk("R1 extra bits cnt", cnt, 33);
      chk("R1 extra bits swal", swal, 3);

      // R8: reset while loaded
      m0 = mcount; r0 = rcount;
      @(negedge dclk); rst_n = 1'b0;
      @(negedge dclk);
      chk("R8 reset cnt", cnt, 0);
      chk("R8 reset ref", refr, 0);
      chk("R8 reset ok", ok, 0);
      rst_n = 1'b1;
      settle();
      chk("R7 no strobe from reset", (mcount - m0) + (rcount - r0), 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule